// File: doc/BRIEF.md
# Variable-range memory type matcher

This block resolves the caching type of a physical address against a set of programmable address windows. Each window is described by a base register and a mask register. An address belongs to a window when the address, ANDed with the window's mask, equals the window's base ANDed with the same mask. The comparison uses address bits 35:12 only, so windows are naturally aligned and at least 4 KB in size. The base register also carries the window's memory type code. A bit in the mask register turns the window on or off.

A lookup address is presented every cycle, and the result is captured in output registers on the following clock edge. The result is one of three outcomes:
- one or more enabled windows match: the matching types are combined by fixed overlap rules, and the hit flag is raised;
- no enabled window matches: the result is a programmable fallback type, and the hit flag is low;
- the matching types cannot be combined: the result falls back to uncached and a conflict flag is raised.

Software programs the windows and the fallback type through a single-cycle write port. Each write sets one register.

Top module: `vrange_type_matcher`

## Requirements
- R1: After reset, every window is disabled and the fallback type is 0 (uncached). The registered result therefore reads type 0, hit 0 and conflict 0.
- R2: Window selection on the write port:
  - `wr_addr` = 2*i selects the base register of window i, and `wr_addr` = 2*i+1 selects its mask register (i from 0 to 7).
  - The base field is taken from data bits 35:12 and the mask field from data bits 35:12.
  - An address matches when (addr[35:12] & mask) == (base & mask). Address bits 11:0 never affect matching.
- R3: Mask register bit 11 enables the window. A window whose enable bit is 0 never matches.
- R4: The type code is base register bits 7:0. Codes: 0 uncached, 1 write-combining, 4 write-through, 5 write-protect, 6 write-back. A single matching window yields its own code, with hit 1 and conflict 0.
- R5: When no enabled window matches, the result type is the fallback register, with hit 0 and conflict 0.
- R6: When several windows match and any of them has type 0, the result is type 0, with hit 1 and conflict 0.
- R7: When the matching windows hold only types 4 and 6, and both are present, the result is type 4 with conflict 0.
- R8: When all matching windows hold the same type, the result is that type with conflict 0.
- R9: Any other mix of matching types gives type 0, hit 1 and conflict 1.
- R10: A write changes the lookup result only from the next clock edge onward. A lookup in the same cycle as the write still sees the old settings. The result for an address appears one clock edge after the address is presented.
- R11: `wr_addr` = 16 writes the fallback type from data bits 7:0. The other data bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register select: window base/mask, or 16 for the fallback type |
| wr_data | input | 64 | Write data |
| lk_addr | input | 36 | Physical address to classify |
| res_type | output | 8 | Resolved memory type code |
| res_hit | output | 1 | Some enabled window matched |
| res_conflict | output | 1 | Matching types could not be combined |

## Verification
The assertions assume that the lookup address and the write port are driven with settled values every cycle once reset is released. They also assume that `wr_addr` values above 16 select nothing. The stimulus changes inputs only on the falling clock edge and uses only defined register selects. Overlapping windows are built deliberately so that each combining rule is exercised, including a write and a lookup issued in the same cycle.

// File: rtl/vrange_type_matcher.sv
module vrange_type_matcher #(
  parameter int NPAIRS = 8,
  parameter int AW     = 36,
  parameter int TW     = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [$clog2(2*NPAIRS+1)-1:0]   wr_addr,
  input  logic [63:0]                     wr_data,
  input  logic [AW-1:0]                   lk_addr,
  output logic [TW-1:0]                   res_type,
  output logic                            res_hit,
  output logic                            res_conflict
);
  localparam int FW  = AW - 12;
  localparam int WAW = $clog2(2*NPAIRS+1);
  localparam logic [TW-1:0] T_UC = TW'(0);
  localparam logic [TW-1:0] T_WT = TW'(4);
  localparam logic [TW-1:0] T_WB = TW'(6);

  logic [FW-1:0]     base_f [NPAIRS];
  logic [FW-1:0]     mask_f [NPAIRS];
  logic [TW-1:0]     type_f [NPAIRS];
  logic [NPAIRS-1:0] en;
  logic [TW-1:0]     dflt;
  logic [NPAIRS-1:0] hit_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en   <= '0;
      dflt <= T_UC;
      for (int i = 0; i < NPAIRS; i++) begin
        base_f[i] <= '0;
        mask_f[i] <= '0;
        type_f[i] <= '0;
      end
    end else if (wr_en) begin
      for (int i = 0; i < NPAIRS; i++) begin
        if (wr_addr == WAW'(2*i)) begin
          base_f[i] <= wr_data[AW-1:12];
          type_f[i] <= wr_data[TW-1:0];
        end
        if (wr_addr == WAW'(2*i+1)) begin
          mask_f[i] <= wr_data[AW-1:12];
          en[i]     <= wr_data[11];
        end
      end
      if (wr_addr == WAW'(2*NPAIRS)) dflt <= wr_data[TW-1:0];
    end
  end

  for (genvar g = 0; g < NPAIRS; g++) begin : g_match
    assign hit_v[g] = en[g] && ((lk_addr[AW-1:12] & mask_f[g]) == (base_f[g] & mask_f[g]));
  end

  logic [TW-1:0] first_t, n_type;
  logic          found, same, any_uc, only_wtwb, n_err;

  always_comb begin
    first_t   = T_UC;
    found     = 1'b0;
    same      = 1'b1;
    any_uc    = 1'b0;
    only_wtwb = 1'b1;
    for (int i = 0; i < NPAIRS; i++) begin
      if (hit_v[i]) begin
        if (!found) begin
          first_t = type_f[i];
          found   = 1'b1;
        end else if (type_f[i] != first_t) begin
          same = 1'b0;
        end
        if (type_f[i] == T_UC) any_uc = 1'b1;
        if (type_f[i] != T_WT && type_f[i] != T_WB) only_wtwb = 1'b0;
      end
    end
    n_err = 1'b0;
    if (!found)         n_type = dflt;
    else if (any_uc)    n_type = T_UC;
    else if (same)      n_type = first_t;
    else if (only_wtwb) n_type = T_WT;
    else begin
      n_type = T_UC;
      n_err  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_type     <= T_UC;
      res_hit      <= 1'b0;
      res_conflict <= 1'b0;
    end else begin
      res_type     <= n_type;
      res_hit      <= |hit_v;
      res_conflict <= n_err;
    end
  end

  a_r5_miss_gives_default: assert property (@(posedge clk) disable iff (!rst_n)
    !res_hit |-> res_type == $past(dflt));
  a_r5_miss_no_conflict: assert property (@(posedge clk) disable iff (!rst_n)
    !res_hit |-> !res_conflict);
  a_r9_conflict_is_uc_hit: assert property (@(posedge clk) disable iff (!rst_n)
    res_conflict |-> (res_type == T_UC && res_hit));
  a_r3_none_enabled_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en) == '0 |-> !res_hit);
endmodule

// File: tb/vrange_type_matcher_test.sv
`timescale 1ns/1ps
module vrange_type_matcher_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic [35:0] lk_addr = '0;
  logic [7:0]  res_type;
  logic        res_hit, res_conflict;

  vrange_type_matcher uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .lk_addr(lk_addr), .res_type(res_type), .res_hit(res_hit), .res_conflict(res_conflict)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    logic [7:0] t;
    logic       h;
    logic       e;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done  = 0;

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t x;
      x = q.pop_front();
      n_vec++;
      if (res_type !== x.t || res_hit !== x.h || res_conflict !== x.e) begin
        n_bad++;
        $display("FAIL %s: got type=%0d hit=%0b conflict=%0b, expected type=%0d hit=%0b conflict=%0b",
                 x.tag, res_type, res_hit, res_conflict, x.t, x.h, x.e);
      end
    end
  end

  task automatic push(input logic [7:0] t, input logic h, input logic e, input string tag);
    exp_t x;
    x.t = t; x.h = h; x.e = e; x.tag = tag;
    q.push_back(x);
  endtask

  task automatic look(input logic [35:0] a, input logic [7:0] t, input logic h,
                      input logic e, input string tag);
    @(negedge clk);
    wr_en   = 1'b0;
    lk_addr = a;
    push(t, h, e, tag);
  endtask

  task automatic wr(input logic [4:0] ad, input logic [63:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = ad;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_look(input logic [4:0] ad, input logic [63:0] d, input logic [35:0] a,
                         input logic [7:0] t, input logic h, input logic e, input string tag);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = ad;
    wr_data = d;
    lk_addr = a;
    push(t, h, e, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    look(36'h0, 8'd0, 1'b0, 1'b0, "R1 reset state");
    look(36'hA_0000_0000, 8'd0, 1'b0, 1'b0, "R1 reset state high address");

    wr(5'd0, 64'h0000_0000_0000_0006);
    wr(5'd1, 64'h0000_000F_FC00_0800);
    look(36'h0_03FF_FFFF, 8'd6, 1'b1, 1'b0, "R4 R2 top of 64MB window");
    look(36'h0_0400_0000, 8'd0, 1'b0, 1'b0, "R5 R2 just past window");

    wr(5'd2, 64'h0000_0000_0020_0000);
    wr_look(5'd3, 64'h0000_000F_FFE0_0800, 36'h0_002A_BCDE, 8'd6, 1'b1, 1'b0, "R10 old settings during write");
    look(36'h0_002A_BCDE, 8'd0, 1'b1, 1'b0, "R6 UC overlaps WB");
    look(36'h0_0040_0000, 8'd6, 1'b1, 1'b0, "R2 outside 2MB window");

    wr(5'd4, 64'h0000_0000_0040_0004);
    wr(5'd5, 64'h0000_000F_FFC0_0800);
    look(36'h0_0050_0FFF, 8'd4, 1'b1, 1'b0, "R7 WT with WB");

    wr(5'd6, 64'h0000_0000_0100_0006);
    wr(5'd7, 64'h0000_000F_FF80_0800);
    look(36'h0_0120_0000, 8'd6, 1'b1, 1'b0, "R8 WB with WB");

    wr(5'd8, 64'h0000_0000_A000_0001);
    wr(5'd9, 64'h0000_000F_FF80_0800);
    look(36'h0_A012_3456, 8'd1, 1'b1, 1'b0, "R4 single WC window");
    wr(5'd10, 64'h0000_0000_A000_0005);
    wr(5'd11, 64'h0000_000F_FFC0_0800);
    look(36'h0_A012_3456, 8'd0, 1'b1, 1'b1, "R9 WC with WP conflict");
    look(36'h0_A060_0000, 8'd1, 1'b1, 1'b0, "R4 WC only past WP window");

    wr(5'd12, 64'h0000_0000_8000_0006);
    wr(5'd13, 64'h0000_000F_F000_0000);
    look(36'h0_8000_0000, 8'd0, 1'b0, 1'b0, "R3 disabled window ignored");
    wr(5'd16, 64'hFFFF_FFFF_ABCD_0006);
    look(36'h0_8000_0000, 8'd6, 1'b0, 1'b0, "R11 R5 default from low byte");
    wr(5'd13, 64'h0000_000F_F000_0800);
    look(36'h0_8000_0000, 8'd6, 1'b1, 1'b0, "R3 enabled window hits");
    wr(5'd3, 64'h0000_000F_FFE0_0000);
    look(36'h0_002A_BCDE, 8'd6, 1'b1, 1'b0, "R3 UC window turned off");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule